// File: doc/BRIEF.md
# SMBASE RAM Guard Register

This block holds a single byte of configuration state that governs a fixed RAM window at the default save-state base used by system-management mode. Firmware first sends a discovery code to confirm the feature is present. The block answers with an acknowledge code. After that, firmware can set a lock bit that cannot be cleared. Once the lock bit is set, ordinary processor accesses that land in the window are sent to a sink: reads return all ones and writes are dropped. Accesses made in system-management mode still reach DRAM through the window.

A static strap says whether the feature exists. When the strap is low, the register ignores every write, reads zero, and never hides the window. The block does not model the DRAM path itself. For each access it presents, it produces a registered routing decision one cycle later.

Top module: `smb_guard`

## Requirements
- R1: During and after synchronous reset, `cfg_value` is 0x00 and `rsp_valid` is 0.
- R2: With `feat_en` low, configuration writes of any value leave `cfg_value` at 0x00, and in-window accesses are routed to DRAM and never blocked.
- R3: From the reset state, a write of the discovery code 0xFF makes `cfg_value` read 0x01 (acknowledge) in the cycle after the write.
- R4: From the reset state, a write of any value other than 0xFF is discarded and `cfg_value` stays 0x00. This includes a value with the lock bit (bit 1) set.
- R5: In the acknowledged state, only bit 1 is writable. A write with bit 1 clear leaves 0x01. A write with bit 1 set makes `cfg_value` read exactly 0x02 in the next cycle.
- R6: Once `cfg_value` is 0x02 (locked), every later write, including 0xFF and 0x00, leaves it at 0x02 until reset.
- R7: While locked, a non-SMM access inside [WIN_BASE, WIN_BASE+WIN_SIZE) (default 0x30000, 128 KiB) gives, one cycle later, `rsp_blocked`=1, `rsp_to_dram`=0, and `rsp_rdata` all ones.
- R8: While locked, an SMM access inside the window gives `rsp_to_dram`=1, `rsp_blocked`=0, and `rsp_smm_win`=1.
- R9: Accesses outside the window (for example 0x2FFFF and 0x50000) always go to DRAM unblocked, with `rsp_rdata` zero.
- R10: Before the lock is set, in-window non-SMM accesses go to DRAM unblocked.
- R11: Reset returns a locked register to 0x00, and the window becomes visible again.
- R12: `cfg_value` only ever holds 0x00, 0x01 or 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Static strap: feature present |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_value | output | 8 | Registered register value (read data) |
| acc_valid | input | 1 | Memory access request valid |
| acc_smm | input | 1 | Request issued in system-management mode |
| acc_addr | input | ADDR_W | Request address |
| rsp_valid | output | 1 | Routing decision valid (one cycle after request) |
| rsp_to_dram | output | 1 | Access proceeds to DRAM |
| rsp_blocked | output | 1 | Access sunk: read all ones, write dropped |
| rsp_smm_win | output | 1 | SMM access reached the hidden window |
| rsp_rdata | output | DATA_W | Sink read data (all ones when blocked, else zero) |

## Verification
The hardest state to reach is a locked register, because a lock only takes effect after a discovery write. A direct lock-bit write from reset is discarded, so the stimulus always goes through reset, then discovery, then the lock write, and confirms each step through `cfg_value`. After the lock is set, the bench sends discovery and clearing writes to show they change nothing. It then sends SMM and non-SMM accesses at both window edges and just outside them, and finally repeats the sequence with the strap low.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [7:0] QUERY_CODE = 8'hFF;
  localparam logic [7:0] ACK_CODE   = 8'h01;
  localparam int         LOCK_POS   = 1;
  localparam logic [7:0] LOCK_CODE  = 8'h02;

  typedef enum logic [1:0] {
    GS_IDLE   = 2'd0,
    GS_ACKED  = 2'd1,
    GS_LOCKED = 2'd2
  } guard_state_t;

  function automatic logic [7:0] state_value(guard_state_t s);
    case (s)
      GS_ACKED:  state_value = ACK_CODE;
      GS_LOCKED: state_value = LOCK_CODE;
      default:   state_value = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_lock_reg.sv
module smb_lock_reg
  import smb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       feat_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] value_q,
  output logic       locked_q
);
  guard_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!feat_en) begin
      state_d = GS_IDLE;
    end else if (wr_en) begin
      case (state_q)
        GS_IDLE:   if (wdata == QUERY_CODE) state_d = GS_ACKED;
        GS_ACKED:  if (wdata[LOCK_POS]) state_d = GS_LOCKED;
        default:   state_d = GS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= GS_IDLE;
      value_q  <= 8'h00;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      value_q  <= state_value(state_d);
      locked_q <= (state_d == GS_LOCKED);
    end
  end
endmodule

// File: rtl/smb_range_decode.sv
module smb_range_decode #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h30000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int  SZ_LOG  = $clog2(WIN_SIZE);
  localparam bit  POW2    = ((WIN_SIZE & (WIN_SIZE - 1'b1)) == '0);
  localparam bit  ALIGNED = POW2 && ((WIN_BASE & (WIN_SIZE - 1'b1)) == '0);

  generate
    if (ALIGNED) begin : g_mask
      logic [ADDR_W-1:0] diff;
      always_comb begin
        diff = addr ^ WIN_BASE;
        hit  = ((diff >> SZ_LOG) == '0);
      end
    end else begin : g_sub
      logic [ADDR_W-1:0] off;
      always_comb begin
        off = addr - WIN_BASE;
        hit = (off < WIN_SIZE);
      end
    end
  endgenerate
endmodule

// File: rtl/smb_route.sv
module smb_route #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_smm,
  input  logic              hit,
  input  logic              locked,
  output logic              rsp_valid,
  output logic              rsp_to_dram,
  output logic              rsp_blocked,
  output logic              rsp_smm_win,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic hide_now;
  assign hide_now = locked && hit && !acc_smm;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_to_dram <= 1'b0;
      rsp_blocked <= 1'b0;
      rsp_smm_win <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= acc_valid;
      rsp_to_dram <= acc_valid && !hide_now;
      rsp_blocked <= acc_valid && hide_now;
      rsp_smm_win <= acc_valid && locked && hit && acc_smm;
      rsp_rdata   <= (acc_valid && hide_now) ? '1 : '0;
    end
  end
endmodule

// File: rtl/smb_guard.sv
module smb_guard #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h30000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 'h20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              feat_en,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_value,
  input  logic              acc_valid,
  input  logic              acc_smm,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rsp_valid,
  output logic              rsp_to_dram,
  output logic              rsp_blocked,
  output logic              rsp_smm_win,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic locked;
  logic hit;

  smb_lock_reg u_reg (
    .clk(clk), .rst(rst), .feat_en(feat_en),
    .wr_en(cfg_wr_en), .wdata(cfg_wdata),
    .value_q(cfg_value), .locked_q(locked)
  );

  smb_range_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_dec (
    .addr(acc_addr), .hit(hit)
  );

  smb_route #(.DATA_W(DATA_W)) u_route (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_smm(acc_smm),
    .hit(hit), .locked(locked),
    .rsp_valid(rsp_valid), .rsp_to_dram(rsp_to_dram), .rsp_blocked(rsp_blocked),
    .rsp_smm_win(rsp_smm_win), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/smb_guard_chk.sv
module smb_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       feat_en,
  input logic       cfg_wr_en,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_value,
  input logic       acc_smm,
  input logic       rsp_valid,
  input logic       rsp_to_dram,
  input logic       rsp_blocked
);
  // R12
  value_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_value == 8'h00) || (cfg_value == 8'h01) || (cfg_value == 8'h02));

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_value == 8'h02) && feat_en |=> (cfg_value == 8'h02));

  // R2
  strap_off_chk: assert property (@(posedge clk) disable iff (rst)
    !feat_en |=> (cfg_value == 8'h00) && !rsp_blocked);

  // R4
  discard_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_value == 8'h00) && cfg_wr_en && (cfg_wdata != 8'hFF) |=> (cfg_value == 8'h00));

  // R7
  route_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_to_dram != rsp_blocked));

  // R8
  smm_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_blocked |-> !$past(acc_smm) && ($past(cfg_value) == 8'h02));
endmodule

bind smb_guard smb_guard_chk u_chk (
  .clk(clk), .rst(rst), .feat_en(feat_en), .cfg_wr_en(cfg_wr_en),
  .cfg_wdata(cfg_wdata), .cfg_value(cfg_value), .acc_smm(acc_smm),
  .rsp_valid(rsp_valid), .rsp_to_dram(rsp_to_dram), .rsp_blocked(rsp_blocked)
);

// File: tb/smb_guard_bench.sv
module smb_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        feat_en = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        acc_valid = 1'b0;
  logic        acc_smm = 1'b0;
  logic [31:0] acc_addr = 32'h0;
  logic [7:0]  cfg_value;
  logic        rsp_valid, rsp_to_dram, rsp_blocked, rsp_smm_win;
  logic [31:0] rsp_rdata;

  always #2 clk = ~clk;

  smb_guard u_smb_guard (
    .clk(clk), .rst(rst), .feat_en(feat_en),
    .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_value(cfg_value),
    .acc_valid(acc_valid), .acc_smm(acc_smm), .acc_addr(acc_addr),
    .rsp_valid(rsp_valid), .rsp_to_dram(rsp_to_dram), .rsp_blocked(rsp_blocked),
    .rsp_smm_win(rsp_smm_win), .rsp_rdata(rsp_rdata)
  );

  typedef struct {
    string       tag;
    logic [7:0]  cfg;
    logic        vld;
    logic        dram;
    logic        blk;
    logic        win;
    logic [31:0] rdata;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Monitor: one item per cycle, compared just after the capturing edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cfg_value !== e.cfg || rsp_valid !== e.vld || rsp_to_dram !== e.dram ||
          rsp_blocked !== e.blk || rsp_smm_win !== e.win || rsp_rdata !== e.rdata) begin
        failures++;
        $display("FAIL %s: actual cfg=%02h v=%0b dram=%0b blk=%0b win=%0b rd=%08h expected cfg=%02h v=%0b dram=%0b blk=%0b win=%0b rd=%08h",
                 e.tag, cfg_value, rsp_valid, rsp_to_dram, rsp_blocked, rsp_smm_win, rsp_rdata,
                 e.cfg, e.vld, e.dram, e.blk, e.win, e.rdata);
      end
    end
  end

  task automatic push(string tag, logic [7:0] cfg, logic vld, logic dram,
                      logic blk, logic win, logic [31:0] rd);
    exp_t e;
    e.tag = tag; e.cfg = cfg; e.vld = vld; e.dram = dram;
    e.blk = blk; e.win = win; e.rdata = rd;
    sb.push_back(e);
  endtask

  task automatic idle_inputs();
    cfg_wr_en = 1'b0; cfg_wdata = 8'h00;
    acc_valid = 1'b0; acc_smm = 1'b0; acc_addr = 32'h0;
  endtask

  task automatic wr(string tag, logic [7:0] d, logic [7:0] exp_cfg);
    @(negedge clk);
    idle_inputs();
    cfg_wr_en = 1'b1; cfg_wdata = d;
    push(tag, exp_cfg, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic acc(string tag, logic smm, logic [31:0] a, logic [7:0] exp_cfg,
                     logic blk, logic win);
    @(negedge clk);
    idle_inputs();
    acc_valid = 1'b1; acc_smm = smm; acc_addr = a;
    push(tag, exp_cfg, 1'b1, !blk, blk, win, blk ? 32'hFFFF_FFFF : 32'h0);
  endtask

  task automatic idle_check(string tag, logic [7:0] exp_cfg);
    @(negedge clk);
    idle_inputs();
    push(tag, exp_cfg, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1: outputs during reset
    checks++;
    if (cfg_value !== 8'h00 || rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: actual cfg=%02h v=%0b expected cfg=00 v=0", cfg_value, rsp_valid);
    end
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    idle_check("R1 after reset", 8'h00);
    acc("R10 open window normal", 1'b0, 32'h0003_0000, 8'h00, 1'b0, 1'b0);
    acc("R10 open window smm", 1'b1, 32'h0004_FFFF, 8'h00, 1'b0, 1'b0);
    wr("R4 lock bit from reset", 8'h02, 8'h00);
    wr("R4 0xFE from reset", 8'hFE, 8'h00);
    wr("R4 0x01 from reset", 8'h01, 8'h00);
    wr("R3 query", 8'hFF, 8'h01);
    idle_check("R3 ack holds", 8'h01);
    wr("R5 bit1 clear 0x01", 8'h01, 8'h01);
    wr("R5 bit1 clear 0xFD", 8'hFD, 8'h01);
    acc("R10 acked window open", 1'b0, 32'h0003_1234, 8'h01, 1'b0, 1'b0);
    wr("R5 lock", 8'h02, 8'h02);
    wr("R6 query after lock", 8'hFF, 8'h02);
    wr("R6 clear after lock", 8'h00, 8'h02);
    wr("R6 ack after lock", 8'h01, 8'h02);
    acc("R7 low edge", 1'b0, 32'h0003_0000, 8'h02, 1'b1, 1'b0);
    acc("R7 high edge", 1'b0, 32'h0004_FFFF, 8'h02, 1'b1, 1'b0);
    acc("R8 smm low edge", 1'b1, 32'h0003_0000, 8'h02, 1'b0, 1'b1);
    acc("R8 smm high edge", 1'b1, 32'h0004_FFFF, 8'h02, 1'b0, 1'b1);
    acc("R9 below window", 1'b0, 32'h0002_FFFF, 8'h02, 1'b0, 1'b0);
    acc("R9 above window", 1'b0, 32'h0005_0000, 8'h02, 1'b0, 1'b0);
    acc("R9 smm outside", 1'b1, 32'h0005_0000, 8'h02, 1'b0, 1'b0);
    idle_check("R6 still locked", 8'h02);
    do_reset();
    idle_check("R11 reset unlocks", 8'h00);
    acc("R11 window visible", 1'b0, 32'h0003_8000, 8'h00, 1'b0, 1'b0);
    feat_en = 1'b0;
    do_reset();
    wr("R2 query ignored", 8'hFF, 8'h00);
    wr("R2 lock ignored", 8'h02, 8'h00);
    acc("R2 never hidden", 1'b0, 32'h0003_0000, 8'h00, 1'b0, 1'b0);
    idle_check("R2 stays zero", 8'h00);
    @(negedge clk);
    idle_inputs();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule